// File: doc/BRIEF.md
# Seek Verify Track Checker

After a head-positioning command that asked for verification, this block confirms that the head sits on the intended track. The surrounding controller pulses `verify_go_i` once the head is loaded and the settle delay has elapsed. From then on the block looks at every decoded ID field that the read path reports. Each field arrives as a track byte and a CRC-good flag. The block compares the track byte with the track register value.

The search succeeds on the first ID field whose track matches and whose CRC is good. It fails if five revolutions pass without such a field. Revolutions are counted as rising edges of the index input. Either outcome sets `done_o`, fires a one-cycle `irq_o`, and on failure also raises `seek_err_o`. `done_o` and `seek_err_o` stay set until the next command begins on `cmd_start_i`, or until a new verification is launched.

Top module: `seek_verify_checker`

## Requirements
- R1: While reset is asserted and just after it is released, `done_o`, `seek_err_o` and `irq_o` are all 0.
- R2: During a search, an ID field with `id_crc_ok_i`=1 and `id_track_i` equal to `trk_reg_i` ends the search. On the next clock, `done_o`=1, `seek_err_o`=0 and `irq_o`=1.
- R3: During a search, an ID field with a mismatching track or `id_crc_ok_i`=0 does not end the search. A later good field still ends it with success.
- R4: The fifth rising edge of `index_i` seen during a search, with no good field found, ends the search. On the next clock, `done_o`=1, `seek_err_o`=1 and `irq_o`=1.
- R5: Fewer than five index rising edges do not end the search. An index level held high for several cycles counts as a single edge.
- R6: When a good ID field and the fifth index edge arrive in the same cycle, the result is success (`seek_err_o`=0).
- R7: When no search is running, ID fields and index edges have no effect on any output.
- R8: `done_o` and `seek_err_o` hold their values until `cmd_start_i`. `cmd_start_i` clears both, aborts a running search, and overrides a simultaneous `verify_go_i`.
- R9: `irq_o` is high for exactly one cycle per completed verification.
- R10: `verify_go_i` during a running search is ignored. The revolution count is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_start_i | input | 1 | Pulse when a new command begins; clears results and aborts a search |
| verify_go_i | input | 1 | Pulse when the settle time has ended; starts the search |
| trk_reg_i | input | TRK_W | Expected track (track register value) |
| id_valid_i | input | 1 | One-cycle strobe: an ID field was decoded |
| id_track_i | input | TRK_W | Track byte of the decoded ID field |
| id_crc_ok_i | input | 1 | CRC of the decoded ID field was correct |
| index_i | input | 1 | Index hole signal, one pulse per revolution |
| done_o | output | 1 | Verification finished (held) |
| seek_err_o | output | 1 | Verification failed (held) |
| irq_o | output | 1 | One-cycle interrupt request at completion |

## Verification
The compare path is swept over every pairing of expected track and ID track in a small range, with both CRC values. This separates a track mismatch, a CRC failure and a true match. Each non-matching field is then followed by a good one, which shows that the search kept running. The revolution limit is probed by counting edges from zero to five, with index pulses of different widths. This tells an edge count apart from a level count. Separate cases cover match-versus-limit collision in one cycle, abort by a new command, the command/verify collision, a verify request ignored mid-search, and stimuli sent while idle.

// File: rtl/svc_pkg.sv
package svc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_DONE   = 2'd2
    } svc_state_e;

    typedef struct packed {
        svc_state_e state;
        logic       done;
        logic       err;
        logic       irq;
    } svc_regs_t;

endpackage

// File: rtl/svc_id_match.sv
module svc_id_match #(
    parameter int TRK_W = 8
) (
    input  logic             valid_i,
    input  logic [TRK_W-1:0] track_i,
    input  logic             crc_ok_i,
    input  logic [TRK_W-1:0] expect_i,
    output logic             hit_o
);

    logic same_trk;

    always_comb begin
        same_trk = (track_i == expect_i);
        hit_o    = valid_i && crc_ok_i && same_trk;
    end

endmodule

// File: rtl/svc_rev_counter.sv
module svc_rev_counter #(
    parameter int LIMIT = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic enable_i,
    input  logic index_i,
    output logic limit_o
);

    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          idx;
        logic [CW-1:0] cnt;
    } rev_regs_t;

    rev_regs_t r_q, r_d;
    logic      rise;

    always_comb begin
        r_d     = r_q;
        rise    = index_i && !r_q.idx;
        limit_o = enable_i && rise && (r_q.cnt == CW'(LIMIT - 1));
        r_d.idx = index_i;
        if (clear_i) begin
            r_d.cnt = '0;
        end else if (enable_i && rise && !limit_o) begin
            r_d.cnt = r_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    p_cnt_below_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.cnt < CW'(LIMIT));

    p_clear_zeroes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (r_q.cnt == '0));

endmodule

// File: rtl/seek_verify_checker.sv
module seek_verify_checker
    import svc_pkg::*;
#(
    parameter int TRK_W     = 8,
    parameter int REV_LIMIT = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cmd_start_i,
    input  logic             verify_go_i,
    input  logic [TRK_W-1:0] trk_reg_i,
    input  logic             id_valid_i,
    input  logic [TRK_W-1:0] id_track_i,
    input  logic             id_crc_ok_i,
    input  logic             index_i,
    output logic             done_o,
    output logic             seek_err_o,
    output logic             irq_o
);

    svc_regs_t r_q, r_d;
    logic      searching;
    logic      launch;
    logic      cnt_clear;
    logic      good_id;
    logic      rev_out;

    always_comb begin
        searching = (r_q.state == ST_SEARCH);
        launch    = !cmd_start_i && verify_go_i && !searching;
        cnt_clear = cmd_start_i || launch;
    end

    svc_id_match #(.TRK_W(TRK_W)) match_i (
        .valid_i  (id_valid_i),
        .track_i  (id_track_i),
        .crc_ok_i (id_crc_ok_i),
        .expect_i (trk_reg_i),
        .hit_o    (good_id)
    );

    svc_rev_counter #(.LIMIT(REV_LIMIT)) revs_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clear_i  (cnt_clear),
        .enable_i (searching),
        .index_i  (index_i),
        .limit_o  (rev_out)
    );

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        if (cmd_start_i) begin
            r_d.state = ST_IDLE;
            r_d.done  = 1'b0;
            r_d.err   = 1'b0;
        end else if (launch) begin
            r_d.state = ST_SEARCH;
            r_d.done  = 1'b0;
            r_d.err   = 1'b0;
        end else if (searching) begin
            if (good_id) begin
                r_d.state = ST_DONE;
                r_d.done  = 1'b1;
                r_d.err   = 1'b0;
                r_d.irq   = 1'b1;
            end else if (rev_out) begin
                r_d.state = ST_DONE;
                r_d.done  = 1'b1;
                r_d.err   = 1'b1;
                r_d.irq   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_IDLE, done: 1'b0, err: 1'b0, irq: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o     = r_q.done;
    assign seek_err_o = r_q.err;
    assign irq_o      = r_q.irq;

    p_irq_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);

    p_err_implies_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seek_err_o |-> done_o);

    p_irq_with_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> done_o);

    p_result_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !cmd_start_i && !verify_go_i) |=> (done_o && $stable(seek_err_o)));

    p_good_id_success_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (searching && !cmd_start_i && id_valid_i && id_crc_ok_i && (id_track_i == trk_reg_i))
        |=> (irq_o && !seek_err_o));

    p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!searching) |=> !irq_o);

    p_cmd_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_start_i |=> (!done_o && !seek_err_o));

endmodule

// File: tb/seek_verify_checker_tb.sv
module seek_verify_checker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic          verify_go = 1'b0;
    logic [TW-1:0] trk_reg = '0;
    logic          id_valid = 1'b0;
    logic [TW-1:0] id_track = '0;
    logic          id_crc = 1'b0;
    logic          index = 1'b0;
    logic          done, serr, irq;

    int tests = 0;
    int fails = 0;
    int irq_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seek_verify_checker #(.TRK_W(TW), .REV_LIMIT(5)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(cmd_start), .verify_go_i(verify_go),
        .trk_reg_i(trk_reg), .id_valid_i(id_valid), .id_track_i(id_track),
        .id_crc_ok_i(id_crc), .index_i(index),
        .done_o(done), .seek_err_o(serr), .irq_o(irq)
    );

    always @(negedge clk) if (rst_n && irq) irq_seen++;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic new_cmd();
        cmd_start = 1'b1; step(); cmd_start = 1'b0;
    endtask

    task automatic go();
        verify_go = 1'b1; step(); verify_go = 1'b0;
    endtask

    task automatic send_id(input int t, input bit c);
        id_track = TW'(t); id_crc = c; id_valid = 1'b1;
        step();
        id_valid = 1'b0;
    endtask

    task automatic idx_pulse(input int width);
        index = 1'b1;
        for (int i = 0; i < width; i++) step();
        index = 1'b0;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        step(); step();
        // R1 reset state
        check("R1 done", int'(done), 0);
        check("R1 err", int'(serr), 0);
        check("R1 irq", int'(irq), 0);
        rst_n = 1'b1;
        step();
        check("R1 done after release", int'(done), 0);

        // R7 stimuli while idle
        trk_reg = 8'd3;
        irq_seen = 0;
        send_id(3, 1'b1);
        for (int k = 0; k < 6; k++) idx_pulse(1);
        check("R7 done idle", int'(done), 0);
        check("R7 err idle", int'(serr), 0);
        check("R7 irq idle", irq_seen, 0);

        // R2/R3 sweep of track pairs and CRC
        for (int r = 0; r < 8; r++) begin
            for (int t = 0; t < 8; t++) begin
                for (int c = 0; c < 2; c++) begin
                    bit exp_ok;
                    trk_reg = TW'(r);
                    new_cmd(); go();
                    irq_seen = 0;
                    exp_ok = (c == 1) && (t == r);
                    send_id(t, c[0]);
                    check("R2 irq on field", int'(irq), int'(exp_ok));
                    check("R2 done on field", int'(done), int'(exp_ok));
                    check("R2 err on field", int'(serr), 0);
                    if (!exp_ok) begin
                        send_id(r, 1'b1);
                        check("R3 search continued", int'(done), 1);
                        check("R3 no error", int'(serr), 0);
                    end
                    step();
                    check("R9 one irq", irq_seen, 1);
                end
            end
        end

        // R4/R5 edge counting with varied pulse widths
        for (int w = 1; w <= 3; w++) begin
            trk_reg = 8'd9;
            new_cmd(); go();
            irq_seen = 0;
            for (int k = 1; k <= 5; k++) begin
                index = 1'b1;
                step();
                check("R4 irq at edge", int'(irq), int'(k == 5));
                for (int i = 1; i < w; i++) step();
                index = 1'b0;
                step();
                check("R5 done after edges", int'(done), int'(k == 5));
                check("R4 err after edges", int'(serr), int'(k == 5));
            end
            check("R9 one irq on timeout", irq_seen, 1);
        end

        // R6 match and fifth edge together
        new_cmd(); go();
        for (int k = 0; k < 4; k++) idx_pulse(1);
        index = 1'b1; id_valid = 1'b1; id_track = trk_reg; id_crc = 1'b1;
        step();
        index = 1'b0; id_valid = 1'b0;
        check("R6 done", int'(done), 1);
        check("R6 err", int'(serr), 0);
        step();

        // R8 hold and clear
        new_cmd(); go();
        for (int k = 0; k < 5; k++) idx_pulse(1);
        repeat (10) step();
        check("R8 err held", int'(serr), 1);
        check("R8 done held", int'(done), 1);
        new_cmd();
        check("R8 err cleared", int'(serr), 0);
        check("R8 done cleared", int'(done), 0);

        // R8 abort of a running search
        go();
        for (int k = 0; k < 3; k++) idx_pulse(1);
        new_cmd();
        for (int k = 0; k < 3; k++) idx_pulse(1);
        send_id(int'(trk_reg), 1'b1);
        check("R8 abort done", int'(done), 0);

        // R8 cmd_start overrides verify_go
        cmd_start = 1'b1; verify_go = 1'b1; step();
        cmd_start = 1'b0; verify_go = 1'b0;
        send_id(int'(trk_reg), 1'b1);
        check("R8 collision no search", int'(done), 0);

        // R10 verify_go mid-search ignored
        new_cmd(); go();
        for (int k = 0; k < 3; k++) idx_pulse(1);
        go();
        for (int k = 0; k < 2; k++) idx_pulse(1);
        check("R10 done", int'(done), 1);
        check("R10 err", int'(serr), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule